// File: doc/BRIEF.md
# Parallel slave port controller

This block pairs an 8-bit data port with a control register that can switch the port into a slave-port mode. In normal mode the CPU's data writes set an output latch that drives the pins whenever the direction bit selects output, and its data reads return the levels seen on the pins. In slave-port mode the pins become a data bus for an external host. CPU data accesses then go to a pair of one-byte buffers: an input buffer that the host fills, and an output buffer that the host drains.

The host uses active-low chip-select, read and write strobes. Each strobe passes through a two-flop synchronizer. A small handshake state machine then detects the strobe edges in the CPU clock domain. Its states are HS_IDLE (no transfer), HS_WRITE (a write strobe has been taken and the block waits for its release) and HS_READ (a read strobe is in progress). The transitions are:

- HS_IDLE to HS_WRITE on an asserted write strobe. This captures the bus and raises input-full.
- HS_IDLE to HS_READ on an asserted read strobe.
- HS_WRITE to HS_IDLE on release of the strobe.
- HS_READ to HS_IDLE on release of the strobe. This clears output-full.
- Any state to HS_IDLE when slave mode is left.

The status flags (input-full, output-full, overflow) sit in the control register. Software can never set them. They are forced clear outside slave mode. Inside slave mode they follow only bus transfers and CPU buffer accesses.

Top module: `pslv_port_ctrl`

## Requirements
- R1: After `rst_n` is asserted, `ctl_rdata` equals the power-on value with bits 7..5 cleared (default 0x0F). `pin_out` reads 0 and `pin_oe` reads 0. The control byte fields are: bit 7 input-full, bit 6 output-full, bit 5 overflow, bit 4 slave mode, bits 3..1 spare read/write bits, bit 0 pin direction (1 means input).
- R2: With slave mode clear, a data write loads `dat_wdata & EN_MASK` into the latch, and the latch is updated only when an enabled bit differs. `pin_out` shows the latch, and `pin_oe` equals the inverse of bit 0.
- R3: With slave mode clear, `dat_rdata` returns `pin_in`.
- R4: A control write with bit 4 clear forces bits 7..5 to 0. Bits 7..5 always read 0 while bit 4 is clear.
- R5: A control write with bit 4 set leaves bits 7 and 6 unchanged, whatever is written to them. Writing 0 to bit 5 clears overflow, and writing 1 to bit 5 leaves it unchanged.
- R6: In slave mode, a data write loads the output buffer and sets bit 6. The normal-mode latch is left unchanged.
- R7: In slave mode, a host write (`hst_cs_n` and `hst_wr_n` low) captures `pin_in` into the input buffer and sets bit 7. A CPU data read returns the input buffer and clears bit 7.
- R8: A host write that arrives while bit 7 is already set sets bit 5, and the input buffer takes the new byte.
- R9: In slave mode, while `hst_cs_n` and `hst_rd_n` are both low, `pin_oe` is 1 and `pin_out` shows the output buffer. At all other times in slave mode `pin_oe` is 0. Bit 6 stays set until the read strobe is released, and it clears a few cycles after the release.
- R10: A pulse on `sys_rst` restores the power-on control value. When `IGNORE_WDT` is 1 and `sys_rst_wdt` is 1, the pulse is ignored.
- R11: With slave mode clear, host strobes capture nothing, change no flag and do not alter `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset pulse |
| sys_rst_wdt | input | 1 | Reset cause is the watchdog |
| ctl_wr | input | 1 | CPU write strobe for the control register |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | CPU write strobe for the data register |
| dat_rd | input | 1 | CPU read strobe for the data register |
| dat_wdata | input | DW | CPU data write value |
| dat_rdata | output | DW | CPU data read value |
| pin_in | input | DW | Sampled pin levels / host data bus in |
| pin_out | output | DW | Value driven on the pins |
| pin_oe | output | 1 | Pin output enable |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |

## Verification
A handshake state machine stuck in HS_WRITE or HS_READ shows up as a flag that never changes after the next strobe. This becomes visible in `ctl_rdata` three clock cycles after the host edge: two cycles in the synchronizer and one in the flag register. A flag register that accepts software data would appear in the read-back value on the cycle right after the control write. A buffer steered wrongly would show at once in `dat_rdata`, or in `pin_out` while a read strobe is held. A corrupted normal-mode latch appears on `pin_out` once slave mode is left.

// File: rtl/pslv_pkg.sv
package pslv_pkg;

    localparam int CTL_W  = 8;
    localparam int STB_N  = 3;
    localparam int STB_CS = 0;
    localparam int STB_RD = 1;
    localparam int STB_WR = 2;

    typedef struct packed {
        logic       ibf;
        logic       obf;
        logic       ovf;
        logic       slave_mode;
        logic [2:0] spare;
        logic       pin_in_dir;
    } ctl_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_WRITE = 2'd1,
        HS_READ  = 2'd2
    } hs_state_e;

endpackage

// File: rtl/pslv_strobe_sync.sv
module pslv_strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] sync_n
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] shreg;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg <= '1;
            end else begin
                shreg <= {shreg[STAGES-2:0], raw_n[i]};
            end
        end
        assign sync_n[i] = shreg[STAGES-1];
    end

endmodule

// File: rtl/pslv_host_fsm.sv
module pslv_host_fsm
    import pslv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic cs_n_s,
    input  logic rd_n_s,
    input  logic wr_n_s,
    output logic host_wr_evt,
    output logic host_rd_done
);

    hs_state_e state_q;
    hs_state_e state_d;
    logic      wr_act;
    logic      rd_act;

    assign wr_act = !cs_n_s && !wr_n_s;
    assign rd_act = !cs_n_s && !rd_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        host_wr_evt  = 1'b0;
        host_rd_done = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (mode && wr_act) begin
                    state_d     = HS_WRITE;
                    host_wr_evt = 1'b1;
                end else if (mode && rd_act) begin
                    state_d = HS_READ;
                end
            end
            HS_WRITE: begin
                if (!mode || !wr_act) begin
                    state_d = HS_IDLE;
                end
            end
            HS_READ: begin
                if (!mode) begin
                    state_d = HS_IDLE;
                end else if (!rd_act) begin
                    state_d      = HS_IDLE;
                    host_rd_done = 1'b1;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

endmodule

// File: rtl/pslv_ctl_reg.sv
module pslv_ctl_reg
    import pslv_pkg::*;
#(
    parameter logic [CTL_W-1:0] POR_CTL    = 8'h0F,
    parameter bit               IGNORE_WDT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             sys_rst_wdt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             cpu_dat_rd,
    input  logic             cpu_dat_wr,
    input  logic             host_wr_evt,
    input  logic             host_rd_done,
    output ctl_t             ctl_q
);

    localparam logic [CTL_W-1:0] POR_SAFE = POR_CTL & 8'h1F;

    ctl_t ctl_d;
    ctl_t wr_c;
    logic reset_hit;

    assign wr_c      = ctl_t'(ctl_wdata);
    assign reset_hit = sys_rst && !(IGNORE_WDT && sys_rst_wdt);

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.slave_mode = wr_c.slave_mode;
            ctl_d.spare      = wr_c.spare;
            ctl_d.pin_in_dir = wr_c.pin_in_dir;
            ctl_d.ovf        = ctl_q.ovf & wr_c.ovf;
        end
        if (ctl_q.slave_mode) begin
            if (cpu_dat_rd)   ctl_d.ibf = 1'b0;
            if (host_rd_done) ctl_d.obf = 1'b0;
            if (cpu_dat_wr)   ctl_d.obf = 1'b1;
            if (host_wr_evt) begin
                ctl_d.ibf = 1'b1;
                ctl_d.ovf = ctl_d.ovf | (ctl_q.ibf & !cpu_dat_rd);
            end
        end
        if (ctl_wr && !wr_c.slave_mode) begin
            ctl_d.ibf = 1'b0;
            ctl_d.obf = 1'b0;
            ctl_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= ctl_t'(POR_SAFE);
        end else if (reset_hit) begin
            ctl_q <= ctl_t'(POR_SAFE);
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/pslv_port_ctrl.sv
module pslv_port_ctrl
    import pslv_pkg::*;
#(
    parameter int               DW         = 8,
    parameter logic [DW-1:0]    EN_MASK    = '1,
    parameter logic [CTL_W-1:0] POR_CTL    = 8'h0F,
    parameter bit               IGNORE_WDT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             sys_rst_wdt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [DW-1:0]    dat_wdata,
    output logic [DW-1:0]    dat_rdata,
    input  logic [DW-1:0]    pin_in,
    output logic [DW-1:0]    pin_out,
    output logic             pin_oe,
    input  logic             hst_cs_n,
    input  logic             hst_rd_n,
    input  logic             hst_wr_n
);

    ctl_t          ctl_q;
    logic          mode;
    logic [STB_N-1:0] stb_raw_n;
    logic [STB_N-1:0] stb_sync_n;
    logic          host_wr_evt;
    logic          host_rd_done;
    logic          host_rd_raw;
    logic [DW-1:0] latch_q;
    logic [DW-1:0] obuf_q;
    logic [DW-1:0] ibuf_q;
    logic          latch_we;

    assign mode = ctl_q.slave_mode;

    assign stb_raw_n[STB_CS] = hst_cs_n;
    assign stb_raw_n[STB_RD] = hst_rd_n;
    assign stb_raw_n[STB_WR] = hst_wr_n;

    pslv_strobe_sync #(.N(STB_N), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (stb_raw_n),
        .sync_n (stb_sync_n)
    );

    pslv_host_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .cs_n_s       (stb_sync_n[STB_CS]),
        .rd_n_s       (stb_sync_n[STB_RD]),
        .wr_n_s       (stb_sync_n[STB_WR]),
        .host_wr_evt  (host_wr_evt),
        .host_rd_done (host_rd_done)
    );

    pslv_ctl_reg #(.POR_CTL(POR_CTL), .IGNORE_WDT(IGNORE_WDT)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_rst      (sys_rst),
        .sys_rst_wdt  (sys_rst_wdt),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .cpu_dat_rd   (dat_rd),
        .cpu_dat_wr   (dat_wr),
        .host_wr_evt  (host_wr_evt),
        .host_rd_done (host_rd_done),
        .ctl_q        (ctl_q)
    );

    assign latch_we = dat_wr && !mode && (|((dat_wdata ^ latch_q) & EN_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            obuf_q  <= '0;
            ibuf_q  <= '0;
        end else begin
            if (latch_we)          latch_q <= dat_wdata & EN_MASK;
            if (dat_wr && mode)    obuf_q  <= dat_wdata;
            if (host_wr_evt)       ibuf_q  <= pin_in;
        end
    end

    assign host_rd_raw = !hst_cs_n && !hst_rd_n;
    assign dat_rdata   = mode ? ibuf_q : pin_in;
    assign pin_out     = mode ? obuf_q : latch_q;
    assign pin_oe      = mode ? host_rd_raw : !ctl_q.pin_in_dir;
    assign ctl_rdata   = ctl_q;

endmodule

// File: rtl/pslv_port_ctrl_chk.sv
module pslv_port_ctrl_chk #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] EN_MASK = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_rst,
    input logic          ctl_wr,
    input logic [7:0]    ctl_wdata,
    input logic [7:0]    ctl_rdata,
    input logic          dat_wr,
    input logic          dat_rd,
    input logic [DW-1:0] dat_wdata,
    input logic [DW-1:0] pin_out,
    input logic          pin_oe,
    input logic          hst_cs_n,
    input logic          hst_rd_n,
    input logic          host_wr_evt,
    input logic          host_rd_done
);

    // R4
    flags_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[4] |=> ctl_rdata[7:5] == 3'b000);

    // R4
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |-> ctl_rdata[7:5] == 3'b000);

    // R7
    ibf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[7]) |-> $past(host_wr_evt));

    // R7
    ibf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] && dat_rd && !host_wr_evt && !ctl_wr && !sys_rst |=> !ctl_rdata[7]);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] && ctl_rdata[7] && host_wr_evt && !dat_rd && !ctl_wr && !sys_rst
        |=> ctl_rdata[5]);

    // R9
    obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_done && !dat_wr && !ctl_wr |=> !ctl_rdata[6]);

    // R9
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] && (hst_cs_n || hst_rd_n) |-> !pin_oe);

    // R2
    normal_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] && dat_wr && !ctl_wr && !sys_rst
        |=> pin_out == ($past(dat_wdata) & EN_MASK));

endmodule

bind pslv_port_ctrl pslv_port_ctrl_chk #(.DW(DW), .EN_MASK(EN_MASK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_rst      (sys_rst),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .ctl_rdata    (ctl_rdata),
    .dat_wr       (dat_wr),
    .dat_rd       (dat_rd),
    .dat_wdata    (dat_wdata),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .hst_cs_n     (hst_cs_n),
    .hst_rd_n     (hst_rd_n),
    .host_wr_evt  (host_wr_evt),
    .host_rd_done (host_rd_done)
);

// File: tb/pslv_port_ctrl_test.sv
module pslv_port_ctrl_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_rst = 1'b0;
    logic          sys_rst_wdt = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          dat_wr = 1'b0;
    logic          dat_rd = 1'b0;
    logic [DW-1:0] dat_wdata = '0;
    logic [DW-1:0] dat_rdata;
    logic [DW-1:0] pin_in = '0;
    logic [DW-1:0] pin_out;
    logic          pin_oe;
    logic          hst_cs_n = 1'b1;
    logic          hst_rd_n = 1'b1;
    logic          hst_wr_n = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pslv_port_ctrl #(
        .DW(DW), .EN_MASK(8'hF7), .POR_CTL(8'h0F), .IGNORE_WDT(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .sys_rst_wdt(sys_rst_wdt),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic dat_write(input logic [7:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic dat_read(output logic [7:0] v);
        @(negedge clk); dat_rd = 1'b1; #1 v = dat_rdata;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); pin_in = v; hst_cs_n = 1'b0; hst_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        hst_cs_n = 1'b1; hst_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 ctl", ctl_rdata, 8'h0F);
        chk("R1 pin_oe", {7'b0, pin_oe}, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
    endtask

    task automatic t_normal;
        logic [7:0] v;
        ctl_write(8'h0E);
        chk("R2 oe", {7'b0, pin_oe}, 8'h01);
        dat_write(8'hFF);
        chk("R2 mask", pin_out, 8'hF7);
        dat_write(8'hF7);
        chk("R2 same", pin_out, 8'hF7);
        dat_write(8'h5A);
        chk("R2 change", pin_out, 8'h52);
        pin_in = 8'hA5;
        dat_read(v);
        chk("R3 pins", v, 8'hA5);
    endtask

    task automatic t_ignored;
        host_write(8'h3C);
        chk("R11 flags", ctl_rdata, 8'h0E);
        @(negedge clk); hst_cs_n = 1'b0; hst_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 oe", {7'b0, pin_oe}, 8'h01);
        chk("R11 out", pin_out, 8'h52);
        hst_cs_n = 1'b1; hst_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 ctl", ctl_rdata, 8'h0E);
    endtask

    task automatic t_slave_entry;
        logic [7:0] v;
        ctl_write(8'hF0);
        chk("R5 entry", ctl_rdata, 8'h10);
        dat_read(v);
        chk("R11 ibuf", v, 8'h00);
        dat_write(8'h99);
        chk("R6 obf", ctl_rdata, 8'h50);
        chk("R9 idle oe", {7'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_host_read;
        @(negedge clk); hst_cs_n = 1'b0; hst_rd_n = 1'b0;
        #1;
        chk("R9 oe", {7'b0, pin_oe}, 8'h01);
        chk("R9 bus", pin_out, 8'h99);
        repeat (5) @(negedge clk);
        chk("R9 held", ctl_rdata, 8'h50);
        hst_cs_n = 1'b1; hst_rd_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 clear", ctl_rdata, 8'h10);
    endtask

    task automatic t_host_write;
        logic [7:0] v;
        host_write(8'hC3);
        chk("R7 ibf", ctl_rdata, 8'h90);
        dat_read(v);
        chk("R7 data", v, 8'hC3);
        chk("R7 clear", ctl_rdata, 8'h10);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        host_write(8'h11);
        host_write(8'h22);
        chk("R8 ovf", ctl_rdata, 8'hB0);
        ctl_write(8'h50);
        chk("R5 keep", ctl_rdata, 8'h90);
        dat_read(v);
        chk("R8 data", v, 8'h22);
        chk("R8 after", ctl_rdata, 8'h10);
    endtask

    task automatic t_leave;
        dat_write(8'h44);
        host_write(8'h55);
        chk("R4 both", ctl_rdata, 8'hD0);
        ctl_write(8'hE0);
        chk("R4 forced", ctl_rdata, 8'h00);
        chk("R6 latch", pin_out, 8'h52);
        chk("R2 oe back", {7'b0, pin_oe}, 8'h01);
    endtask

    task automatic t_sysreset;
        ctl_write(8'h06);
        chk("R10 set", ctl_rdata, 8'h06);
        @(negedge clk); sys_rst = 1'b1; sys_rst_wdt = 1'b1;
        @(negedge clk); sys_rst = 1'b0; sys_rst_wdt = 1'b0;
        chk("R10 wdt", ctl_rdata, 8'h06);
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        chk("R10 por", ctl_rdata, 8'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_normal;
        t_ignored;
        t_slave_entry;
        t_host_read;
        t_host_write;
        t_overflow;
        t_leave;
        t_sysreset;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule